// File: doc/BRIEF.md
# Single-Address DMA Engine with Boundary Pause

This block moves a multi-block data transfer between a card-side data buffer and system memory. It acts as a simple memory bus master that issues one 32-bit word per valid/ready handshake. Software programs a start address, a block geometry word, a block count and a transfer mode, and the transfer starts when the mode is written. The block geometry word packs a boundary select above the block length. Each time the running address reaches a multiple of the selected power-of-two boundary, the engine stops, raises a DMA interrupt flag and shows the next address in its address register. Software resumes the transfer by writing that register again, with the same address or a new one. When the last word has moved, a completion flag is raised.

Registers are reached through a write port with a 3-bit select: 0 system address, 1 block geometry, 2 block count, 3 transfer mode, 4 host control, 5 interrupt status. Writing select 3 with bit 0 set while the engine is idle starts a transfer. Only the single-address DMA mode is implemented. The card-line protocol, command handling and descriptor-based DMA are outside this block.

Top module: `sdma_engine`

## Requirements
- R1: After reset the engine is idle (busy low), both interrupt flags are clear, no memory request is raised, and the system address reads 0.
- R2: Each accepted memory handshake moves one 32-bit word, and the system address then advances by 4. A block holds the block length (geometry bits [11:0], in bytes) rounded up to a multiple of 4, divided by 4 words.
- R3: Geometry bits [14:12] hold a select k. The boundary is 2^(BND_BASE_LOG2+k) bytes, which is 4 KiB·2^k by default. When the address after an accepted word is a multiple of the boundary and that word was not the final one, the engine stops requesting, sets the DMA flag (status bit 3), and the system address shows the next address.
- R4: A write to the system address while paused resumes the transfer, and the next word uses the written address.
- R5: When the final word is accepted, the engine goes idle and sets the completion flag (status bit 1). Writing 1 to status bit 1 or bit 3 clears that flag.
- R6: With multi-block (mode bit 5) and count enable (mode bit 1) both set, exactly the programmed number of blocks is moved, and the blocks-left output counts down to 0.
- R7: With mode bit 5 clear, exactly one block is moved, whatever the block count.
- R8: With mode bit 5 set and count enable clear, the blocks-left value is not decremented and the transfer runs on without end.
- R9: A block length of 0, or a block count of 0 with count enable set, completes at once: the completion flag is set and no memory access is made.
- R10: If host control bits [4:3] are not 00, a start request is ignored: the engine stays idle and no flag is set.
- R11: Mode bit 4 = 1 moves data from the card buffer into memory (memory writes). Mode bit 4 = 0 reads memory and pushes the words into the card buffer.
- R12: Writes to the address or configuration registers while a transfer is running (not paused) are ignored.
- R13: When the final word ends exactly on a boundary, only the completion flag is raised. No DMA pause occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| sys_addr_o | output | ADDR_W | Current or next system address |
| blk_left_o | output | CNT_W | Blocks remaining |
| busy_o | output | 1 | Transfer running or paused |
| done_irq_o | output | 1 | Completion flag |
| dma_irq_o | output | 1 | Boundary pause flag |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| cbuf_rd_valid_i | input | 1 | Card buffer has a word for memory |
| cbuf_rd_data_i | input | 32 | Card buffer word |
| cbuf_rd_pop_o | output | 1 | Card buffer word consumed |
| cbuf_wr_ready_i | input | 1 | Card buffer can take a word |
| cbuf_wr_data_o | output | 32 | Word for the card buffer |
| cbuf_wr_push_o | output | 1 | Card buffer word written |

## Verification
The hardest situation to reach is a boundary crossing in the middle of a transfer while the memory and card handshakes stall at irregular times. The pause must land on exactly the right word, and the resume must continue from whatever address software supplies. The bench shrinks the base boundary to 16 bytes and sweeps block lengths, block counts, boundary selects, start offsets and both directions under pseudo-random ready and valid patterns. This produces many pauses per transfer. It also covers the case where the final word falls on a boundary, and a directed resume to a different address.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  typedef enum logic [2:0] {
    SEL_ADDR  = 3'd0,
    SEL_GEOM  = 3'd1,
    SEL_COUNT = 3'd2,
    SEL_MODE  = 3'd3,
    SEL_HOST  = 3'd4,
    SEL_STAT  = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2
  } dma_state_e;

  localparam int MODE_GO     = 0;
  localparam int MODE_CNT_EN = 1;
  localparam int MODE_DIR_RD = 4;
  localparam int MODE_MULTI  = 5;

  localparam int STAT_DONE = 1;
  localparam int STAT_DMA  = 3;

  localparam int BND_SELS = 8;

  typedef struct packed {
    logic [2:0]  bnd_sel;
    logic [11:0] blk_len;
  } geom_t;

endpackage

// File: rtl/sdma_cfg_regs.sv
module sdma_cfg_regs
  import sdma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       sel,
  input  logic [15:0]      wdata,
  output geom_t            geom_o,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_rd_o,
  output logic             multi_o,
  output logic             cnt_en_o,
  output logic [1:0]       dma_mode_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      geom_o     <= '0;
      count_o    <= '0;
      dir_rd_o   <= 1'b0;
      multi_o    <= 1'b0;
      cnt_en_o   <= 1'b0;
      dma_mode_o <= 2'b00;
    end else if (wr_en) begin
      case (reg_sel_e'(sel))
        SEL_GEOM:  geom_o     <= geom_t'(wdata[14:0]);
        SEL_COUNT: count_o    <= wdata[CNT_W-1:0];
        SEL_MODE: begin
          dir_rd_o <= wdata[MODE_DIR_RD];
          multi_o  <= wdata[MODE_MULTI];
          cnt_en_o <= wdata[MODE_CNT_EN];
        end
        SEL_HOST:  dma_mode_o <= wdata[4:3];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sdma_progress.sv
module sdma_progress #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [10:0]      words_per_blk,
  input  logic [CNT_W-1:0] blk_count,
  input  logic             cnt_en,
  input  logic             multi,
  output logic             last_word,
  output logic [CNT_W-1:0] blocks_left
);

  logic [10:0] word_idx;
  logic        blk_end;
  logic        last_blk;

  assign blk_end   = (word_idx == words_per_blk - 11'd1);
  assign last_blk  = !multi ? 1'b1 : (cnt_en ? (blocks_left == CNT_W'(1)) : 1'b0);
  assign last_word = blk_end && last_blk;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_idx    <= '0;
      blocks_left <= '0;
    end else if (load) begin
      word_idx    <= '0;
      blocks_left <= blk_count;
    end else if (step) begin
      if (blk_end) begin
        word_idx <= '0;
        if (cnt_en) blocks_left <= blocks_left - CNT_W'(1);
      end else begin
        word_idx <= word_idx + 11'd1;
      end
    end
  end

endmodule

// File: rtl/sdma_boundary.sv
module sdma_boundary
  import sdma_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  localparam int TOP_BIT  = BASE_LOG2 + BND_SELS - 2
) (
  input  logic [TOP_BIT:0] next_addr,
  input  logic [2:0]       sel,
  output logic             hit
);

  logic [BND_SELS-1:0] hit_v;

  for (genvar g = 0; g < BND_SELS; g++) begin : g_sel
    localparam int LSB = BASE_LOG2 + g;
    assign hit_v[g] = (next_addr[LSB-1:0] == '0);
  end

  assign hit = hit_v[sel];

endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int CNT_W         = 16,
  parameter int BND_BASE_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [ADDR_W-1:0] sys_addr_o,
  output logic [CNT_W-1:0]  blk_left_o,
  output logic              busy_o,
  output logic              done_irq_o,
  output logic              dma_irq_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic              cbuf_rd_valid_i,
  input  logic [31:0]       cbuf_rd_data_i,
  output logic              cbuf_rd_pop_o,
  input  logic              cbuf_wr_ready_i,
  output logic [31:0]       cbuf_wr_data_o,
  output logic              cbuf_wr_push_o
);

  localparam int BND_TOP = BND_BASE_LOG2 + BND_SELS - 2;

  dma_state_e        state;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] next_addr;
  logic              done_q;
  logic              dma_q;

  geom_t             geom;
  logic [CNT_W-1:0]  count;
  logic              dir_rd;
  logic              multi;
  logic              cnt_en;
  logic [1:0]        dma_mode;

  logic              idle;
  logic              start;
  logic              zero_xfer;
  logic              src_ok;
  logic              accept;
  logic              last_word;
  logic              bnd_hit;
  logic [10:0]       words_per_blk;
  logic              addr_wr;
  logic              stat_wr;

  assign idle    = (state == ST_IDLE);
  assign addr_wr = reg_wr && (reg_sel_e'(reg_sel) == SEL_ADDR);
  assign stat_wr = reg_wr && (reg_sel_e'(reg_sel) == SEL_STAT);
  assign start   = reg_wr && idle && (reg_sel_e'(reg_sel) == SEL_MODE)
                   && reg_wdata[MODE_GO] && (dma_mode == 2'b00);

  assign zero_xfer = (geom.blk_len == 12'd0)
                     || (reg_wdata[MODE_CNT_EN] && (count == '0));

  assign words_per_blk = {1'b0, geom.blk_len[11:2]} + {10'd0, |geom.blk_len[1:0]};

  sdma_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_wr && idle),
    .sel        (reg_sel),
    .wdata      (reg_wdata[15:0]),
    .geom_o     (geom),
    .count_o    (count),
    .dir_rd_o   (dir_rd),
    .multi_o    (multi),
    .cnt_en_o   (cnt_en),
    .dma_mode_o (dma_mode)
  );

  assign src_ok = dir_rd ? cbuf_rd_valid_i : cbuf_wr_ready_i;
  assign accept = mem_req_o && mem_ready_i;
  assign next_addr = addr + ADDR_W'(4);

  sdma_progress #(.CNT_W(CNT_W)) u_prog (
    .clk           (clk),
    .rst           (rst),
    .load          (start && !zero_xfer),
    .step          (accept),
    .words_per_blk (words_per_blk),
    .blk_count     (count),
    .cnt_en        (cnt_en),
    .multi         (multi),
    .last_word     (last_word),
    .blocks_left   (blk_left_o)
  );

  sdma_boundary #(.BASE_LOG2(BND_BASE_LOG2)) u_bnd (
    .next_addr (next_addr[BND_TOP:0]),
    .sel       (geom.bnd_sel),
    .hit       (bnd_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      addr   <= '0;
      done_q <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      if (stat_wr && reg_wdata[STAT_DONE]) done_q <= 1'b0;
      if (stat_wr && reg_wdata[STAT_DMA])  dma_q  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (addr_wr) addr <= reg_wdata[ADDR_W-1:0];
          if (start) begin
            if (zero_xfer) done_q <= 1'b1;
            else           state  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (accept) begin
            addr <= next_addr;
            if (last_word) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end else if (bnd_hit) begin
              state <= ST_PAUSE;
              dma_q <= 1'b1;
            end
          end
        end
        ST_PAUSE: begin
          if (addr_wr) begin
            addr  <= reg_wdata[ADDR_W-1:0];
            state <= ST_RUN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sys_addr_o     = addr;
  assign busy_o         = !idle;
  assign done_irq_o     = done_q;
  assign dma_irq_o      = dma_q;
  assign mem_req_o      = (state == ST_RUN) && src_ok;
  assign mem_we_o       = dir_rd;
  assign mem_addr_o     = addr;
  assign mem_wdata_o    = cbuf_rd_data_i;
  assign cbuf_rd_pop_o  = accept && dir_rd;
  assign cbuf_wr_data_o = mem_rdata_i;
  assign cbuf_wr_push_o = accept && !dir_rd;

endmodule

// File: rtl/sdma_engine_chk.sv
module sdma_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [2:0]        reg_sel,
  input logic [ADDR_W-1:0] sys_addr_o,
  input logic              busy_o,
  input logic              done_irq_o,
  input logic              dma_irq_o,
  input logic              mem_req_o,
  input logic              mem_ready_i
);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_ready_i) |=> (sys_addr_o == $past(sys_addr_o) + ADDR_W'(4)));

  // R3
  pause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_irq_o) |-> (busy_o && !mem_req_o));

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_irq_o) |-> !busy_o);

  // R1
  req_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> busy_o);

  // R10
  start_by_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> ($past(reg_wr) && $past(reg_sel) == 3'd3));

endmodule

bind sdma_engine sdma_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr      (reg_wr),
  .reg_sel     (reg_sel),
  .sys_addr_o  (sys_addr_o),
  .busy_o      (busy_o),
  .done_irq_o  (done_irq_o),
  .dma_irq_o   (dma_irq_o),
  .mem_req_o   (mem_req_o),
  .mem_ready_i (mem_ready_i)
);

// File: tb/sim_sdma_engine.sv
`timescale 1ns/1ps
module sim_sdma_engine;

  localparam int ADDR_W = 32;
  localparam int CNT_W  = 8;
  localparam int BASE   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [ADDR_W-1:0] sys_addr_o, mem_addr_o;
  logic [CNT_W-1:0] blk_left_o;
  logic busy_o, done_irq_o, dma_irq_o, mem_req_o, mem_we_o;
  logic [31:0] mem_wdata_o, mem_rdata_i, cbuf_rd_data_i, cbuf_wr_data_o;
  logic mem_ready_i, cbuf_rd_valid_i, cbuf_rd_pop_o, cbuf_wr_ready_i, cbuf_wr_push_o;

  always #4 clk = ~clk;

  sdma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BND_BASE_LOG2(BASE)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .sys_addr_o(sys_addr_o), .blk_left_o(blk_left_o), .busy_o(busy_o),
    .done_irq_o(done_irq_o), .dma_irq_o(dma_irq_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
    .cbuf_rd_valid_i(cbuf_rd_valid_i), .cbuf_rd_data_i(cbuf_rd_data_i),
    .cbuf_rd_pop_o(cbuf_rd_pop_o), .cbuf_wr_ready_i(cbuf_wr_ready_i),
    .cbuf_wr_data_o(cbuf_wr_data_o), .cbuf_wr_push_o(cbuf_wr_push_o)
  );

  function automatic logic [31:0] rd_pat(input logic [31:0] a);
    return {~a[15:0], a[15:0]};
  endfunction

  logic [31:0] mem [256];
  logic [31:0] sink [256];
  int acc_cnt, rd_idx, wr_idx;
  logic clr = 1'b1;
  logic [7:0] lfsr = 8'h5B;
  logic stall_free = 1'b0;

  assign mem_rdata_i    = rd_pat(mem_addr_o);
  assign cbuf_rd_data_i = 32'hA500_0000 | 32'(rd_idx);

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready_i     <= stall_free | lfsr[0] | lfsr[3];
    cbuf_rd_valid_i <= stall_free | lfsr[1] | lfsr[5];
    cbuf_wr_ready_i <= stall_free | lfsr[2] | lfsr[6];
  end

  always @(posedge clk) begin
    if (clr) begin
      acc_cnt <= 0; rd_idx <= 0; wr_idx <= 0;
    end else begin
      if (mem_req_o && mem_ready_i) begin
        acc_cnt <= acc_cnt + 1;
        if (mem_we_o) mem[mem_addr_o[9:2]] <= mem_wdata_o;
      end
      if (cbuf_rd_pop_o) rd_idx <= rd_idx + 1;
      if (cbuf_wr_push_o) begin
        sink[wr_idx[7:0]] <= cbuf_wr_data_o;
        wr_idx <= wr_idx + 1;
      end
    end
  end

  int vecs = 0, fails = 0, cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs + 1, fails + 1);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; clr = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; clr = 1'b0;
  endtask

  function automatic logic [31:0] mode_word(input bit dir, input bit multi, input bit cen);
    return 32'(1) | (32'(cen) << 1) | (32'(dir) << 4) | (32'(multi) << 5);
  endfunction

  task automatic run_xfer(input logic [31:0] start, input int len, input int nblk,
                          input int k, input bit dir, input bit multi, input bit poke);
    int wpb = (len + 3) / 4;
    int w = wpb * (multi ? nblk : 1);
    int bsz = (1 << (BASE + k));
    int exp_p = 0, pauses = 0, guard = 0, errs = 0;
    for (int i = 1; i < w; i++) if (((start + 4 * i) % bsz) == 0) exp_p++;
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
    wr(3'd0, start);
    wr(3'd1, (32'(k) << 12) | 32'(len));
    wr(3'd2, 32'(nblk));
    wr(3'd4, 32'h0);
    wr(3'd3, mode_word(dir, multi, 1'b1));
    while (guard < 5000) begin
      if (dma_irq_o) begin
        pauses++;
        // R3: pause lands on a boundary, right after the last accepted word
        chk("R3 pause aligned", sys_addr_o % bsz, 0);
        chk("R3 pause address", sys_addr_o, start + 4 * acc_cnt);
        wr(3'd5, 32'h8);
        // R5: status bit 3 clears by writing 1
        chk("R5 dma flag clear", 32'(dma_irq_o), 0);
        wr(3'd0, sys_addr_o);
      end else if (!busy_o) break;
      if (poke && guard == 3 && busy_o) begin
        // R12: writes while running are ignored
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h4);
      end
      @(negedge clk);
      guard++;
    end
    if (guard >= 5000) chk("watchdog run", 1, 0);
    // R13: a final word on a boundary gives no pause (exp_p excludes the end)
    chk("R3/R13 pause count", pauses, exp_p);
    chk("R5 done flag", 32'(done_irq_o), 1);
    chk("R2 final address", sys_addr_o, start + 4 * w);
    chk("R2 word count", acc_cnt, w);
    for (int i = 0; i < w; i++) begin
      if (dir) begin
        if (mem[((start >> 2) + i) & 255] !== (32'hA500_0000 | 32'(i))) errs++;
      end else begin
        if (sink[i] !== rd_pat(start + 4 * i)) errs++;
      end
    end
    // R11: direction selects the data path
    chk("R11 data path", errs, 0);
    if (multi) chk("R6 blocks left", 32'(blk_left_o), 0);
    wr(3'd5, 32'h2);
    chk("R5 done clear", 32'(done_irq_o), 0);
  endtask

  initial begin
    do_reset();
    // R1
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 flags", {30'd0, done_irq_o, dma_irq_o}, 0);
    chk("R1 request", 32'(mem_req_o), 0);
    chk("R1 address", sys_addr_o, 0);

    // R2 R3 R6 R11 R13 sweep
    begin
      int n = 0;
      int lens[4] = '{4, 12, 13, 28};
      for (int li = 0; li < 4; li++)
        for (int nb = 1; nb <= 3; nb++)
          for (int k = 0; k < 3; k++)
            for (int d = 0; d < 2; d++) begin
              run_xfer(32'h40 + 32'(4 * ((n * 5) % 8)), lens[li], nb, k, d[0], nb > 1, 1'b0);
              n++;
            end
    end

    // R13: 4 words from 0x10 end exactly on a 16-byte boundary
    run_xfer(32'h10, 16, 1, 0, 1'b1, 1'b0, 1'b0);
    chk("R13 no dma flag", 32'(dma_irq_o), 0);

    // R7: single-block mode ignores the count of 5
    run_xfer(32'h80, 8, 5, 7, 1'b1, 1'b0, 1'b0);

    // R12: address/geometry writes during the run
    run_xfer(32'h100, 40, 2, 7, 1'b0, 1'b1, 1'b1);

    // R4: resume at a different address
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
    wr(3'd0, 32'h20);
    wr(3'd1, 32'd32);
    wr(3'd2, 32'd1);
    wr(3'd3, mode_word(1'b1, 1'b0, 1'b1));
    for (int g = 0; g < 500 && !dma_irq_o; g++) @(negedge clk);
    chk("R4 paused at", sys_addr_o, 32'h30);
    wr(3'd0, 32'h200);
    for (int g = 0; g < 500 && busy_o; g++) @(negedge clk);
    chk("R4 end address", sys_addr_o, 32'h210);
    begin
      int errs = 0;
      for (int j = 0; j < 4; j++)
        if (mem[(32'h200 >> 2) + j] !== (32'hA500_0000 | 32'(4 + j))) errs++;
      chk("R4 resumed data", errs, 0);
    end
    wr(3'd5, 32'hA);

    // R9: zero length
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd3);
    wr(3'd3, mode_word(1'b1, 1'b1, 1'b1));
    chk("R9 zero len done", 32'(done_irq_o), 1);
    chk("R9 zero len busy", 32'(busy_o), 0);
    repeat (4) @(negedge clk);
    chk("R9 zero len access", acc_cnt, 0);
    wr(3'd5, 32'h2);
    // R9: zero count with count enable
    wr(3'd1, 32'd8);
    wr(3'd2, 32'd0);
    wr(3'd3, mode_word(1'b0, 1'b1, 1'b1));
    repeat (4) @(negedge clk);
    chk("R9 zero count done", 32'(done_irq_o), 1);
    chk("R9 zero count access", acc_cnt, 0);
    wr(3'd5, 32'h2);

    // R10: non-single-address DMA mode refuses to start
    wr(3'd4, 32'h10);
    wr(3'd2, 32'd2);
    wr(3'd3, mode_word(1'b1, 1'b1, 1'b1));
    repeat (6) @(negedge clk);
    chk("R10 busy", 32'(busy_o), 0);
    chk("R10 flags", {30'd0, done_irq_o, dma_irq_o}, 0);
    chk("R10 access", acc_cnt, 0);
    wr(3'd4, 32'h0);

    // R8: multi-block with count enable clear runs on
    wr(3'd0, 32'h0);
    wr(3'd1, (32'd7 << 12) | 32'd8);
    wr(3'd2, 32'd4);
    wr(3'd3, 32'h21);
    for (int g = 0; g < 2000 && acc_cnt < 12; g++) @(negedge clk);
    chk("R8 still busy", 32'(busy_o), 1);
    chk("R8 count held", 32'(blk_left_o), 4);
    chk("R8 no done", 32'(done_irq_o), 0);

    do_reset();
    chk("R1 reset after run", 32'(busy_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule